// File: doc/BRIEF.md
# Dual-Path Latch/Register Bus Transceiver

The block moves data between two 20-bit ports, A and B, through two independent paths: A-to-B and B-to-A. Each path keeps one stored word. That word can behave as a transparent latch or as an edge-triggered register, and each path has its own active-low output enable. Every path has four controls: output enable, latch enable, an active-low clock enable, and a path clock. Each port is presented as separate input, output and output-enable vectors, so the tri-state pins can be resolved above this block.

The storage is synchronous to one system clock, `clk`. Each path clock is treated as a sampled level, and its rising edge is detected against the previous sample. While a path is transparent, its output follows its input combinationally, and the stored word is refreshed on every system clock edge. When latch enable drops, the word therefore keeps the last input sampled while the path was open. A test-mode input stops normal operation. It freezes both stored words and turns both output enables off.

Top module: `dual_path_xcvr`

## Requirements
- R1: With latch enable high and test mode low, a path's output equals its input in the same cycle.
- R2: With latch enable low and clock enable high (`*_clken_n` = 1), the stored word, seen at the output, does not change, even across a rising edge of the path clock.
- R3: With latch enable low and clock enable low, a rising edge of the path clock loads the input. The edge is a sample of 1 after a sample of 0 at consecutive `clk` edges. The new word appears at the output after that `clk` edge.
- R4: With latch enable low and the path clock held at a steady level, the stored word does not change, whatever the input does.
- R5: Output enable low drives the path's output-enable vector to all ones. Output enable high drives it to all zeros. Output enable never changes the stored word.
- R6: The two paths are independent: A-to-B uses `ab_*` controls, `a_in`, `b_out` and `b_oe`; B-to-A uses `ba_*` controls, `b_in`, `a_out` and `a_oe`.
- R7: When latch enable falls, the stored word is the input sampled at the last `clk` edge while the path was transparent.
- R8: With test mode high, both output-enable vectors are zero. Both stored words hold, and the outputs show the stored words, not the inputs.
- R9: Reset (`rst_n` low, asynchronous) clears both stored words to zero. It does not override output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Freezes both paths and disables outputs |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (transparent when high) |
| ab_clken_n | input | 1 | A-to-B clock enable, active low |
| ab_clk | input | 1 | A-to-B path clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clken_n | input | 1 | B-to-A clock enable, active low |
| ba_clk | input | 1 | B-to-A path clock |
| a_in | input | 20 | Data read from the A pins |
| a_out | output | 20 | Data for the A pins (B-to-A path) |
| a_oe | output | 20 | Drive enable for the A pins |
| b_in | input | 20 | Data read from the B pins |
| b_out | output | 20 | Data for the B pins (A-to-B path) |
| b_oe | output | 20 | Drive enable for the B pins |

## Verification
A corrupted stored word shows up at the path output in the first cycle in which that path is latched or in test mode. A missed or extra capture shows one `clk` edge after the path-clock edge that should or should not have loaded the word. A stale edge-detector sample shows up as a false or missing capture on the next rising level. Because every cycle is compared with an independent model, a divergence is reported in the cycle it becomes visible, in whichever direction it occurs.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
    localparam int unsigned DPX_WIDTH = 20;
    localparam int unsigned DPX_PATHS = 2;

    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_PASS    = 2'd1,
        UPD_CAPTURE = 2'd2
    } upd_kind_e;
endpackage

// File: rtl/dpx_edge.sv
module dpx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    typedef struct packed {
        logic seen;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = level;
        rise      = level & ~st_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dpx_store.sv
module dpx_store
    import dpx_pkg::*;
#(
    parameter int unsigned W = DPX_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         le,
    input  logic         clken_n,
    input  logic         rise,
    input  logic [W-1:0] din,
    output logic [W-1:0] word,
    output upd_kind_e    kind
);
    typedef struct packed {
        logic [W-1:0] word;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        kind = UPD_HOLD;
        if (!freeze) begin
            if (le) begin
                kind = UPD_PASS;
            end else if (!clken_n && rise) begin
                kind = UPD_CAPTURE;
            end
        end
        if (kind != UPD_HOLD) st_d.word = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;
endmodule

// File: rtl/dpx_drive.sv
module dpx_drive #(
    parameter int unsigned W = 20
) (
    input  logic         freeze,
    input  logic         le,
    input  logic         oe_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] word,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);
    logic pass;
    logic drive;

    always_comb begin
        pass  = le & ~freeze;
        drive = ~oe_n & ~freeze;
        dout  = pass ? din : word;
        oe    = {W{drive}};
    end
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
    import dpx_pkg::*;
#(
    parameter int unsigned W = DPX_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_mode,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_clken_n,
    input  logic         ab_clk,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clken_n,
    input  logic         ba_clk,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    localparam int unsigned NP = DPX_PATHS;

    logic [NP-1:0]       p_oe_n, p_le, p_cen_n, p_clk, p_rise;
    logic [W-1:0]        p_din  [NP];
    logic [W-1:0]        p_word [NP];
    logic [W-1:0]        p_dout [NP];
    logic [W-1:0]        p_oe   [NP];
    upd_kind_e           p_kind [NP];

    // index 0: A-to-B, index 1: B-to-A
    always_comb begin
        p_oe_n  = {ba_oe_n, ab_oe_n};
        p_le    = {ba_le, ab_le};
        p_cen_n = {ba_clken_n, ab_clken_n};
        p_clk   = {ba_clk, ab_clk};
        p_din[0] = a_in;
        p_din[1] = b_in;
        b_out = p_dout[0];
        b_oe  = p_oe[0];
        a_out = p_dout[1];
        a_oe  = p_oe[1];
    end

    for (genvar g = 0; g < NP; g++) begin : g_path
        dpx_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .level (p_clk[g]),
            .rise  (p_rise[g])
        );

        dpx_store #(.W(W)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .freeze  (test_mode),
            .le      (p_le[g]),
            .clken_n (p_cen_n[g]),
            .rise    (p_rise[g]),
            .din     (p_din[g]),
            .word    (p_word[g]),
            .kind    (p_kind[g])
        );

        dpx_drive #(.W(W)) u_drive (
            .freeze (test_mode),
            .le     (p_le[g]),
            .oe_n   (p_oe_n[g]),
            .din    (p_din[g]),
            .word   (p_word[g]),
            .dout   (p_dout[g]),
            .oe     (p_oe[g])
        );
    end
endmodule

// File: rtl/dpx_checker.sv
module dpx_checker #(
    parameter int unsigned W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         test_mode,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_clken_n,
    input logic         ab_clk,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_clken_n,
    input logic         ba_clk,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);
    assert_pass_ab_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !test_mode) |-> b_out == a_in);
    assert_pass_ba_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && !test_mode) |-> a_out == b_in);

    assert_hold_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_clken_n && !test_mode) |=> ((ab_le && !test_mode) || b_out == $past(b_out)));

    assert_capture_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_clken_n && $rose(ab_clk) && !test_mode) |=> ((ab_le && !test_mode) || b_out == $past(a_in)));
    assert_capture_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !ba_clken_n && $rose(ba_clk) && !test_mode) |=> ((ba_le && !test_mode) || a_out == $past(b_in)));

    assert_oe_ab_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> ($countones(b_oe) == (ab_oe_n ? 0 : W)));
    assert_oe_ba_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> ($countones(a_oe) == (ba_oe_n ? 0 : W)));

    assert_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> ($countones(a_oe) == 0 && $countones(b_oe) == 0));
    assert_freeze_ab_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> ((ab_le && !test_mode) || b_out == $past(b_out)));
    assert_freeze_ba_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> ((ba_le && !test_mode) || a_out == $past(a_out)));
endmodule

bind dual_path_xcvr dpx_checker #(.W(W)) u_dpx_checker (.*);

// File: tb/dual_path_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_path_xcvr_tb_top;
    localparam int W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic oen [2], le [2], cen [2], pclk [2];
    logic [W-1:0] din [2];
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    // next-cycle stimulus
    logic n_test;
    logic n_oen [2], n_le [2], n_cen [2], n_pclk [2];
    logic [W-1:0] n_din [2];

    // model
    logic [W-1:0] m_st [2];
    logic m_pc [2];
    string m_tag [2];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_path_xcvr #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .ab_oe_n(oen[0]), .ab_le(le[0]), .ab_clken_n(cen[0]), .ab_clk(pclk[0]),
        .ba_oe_n(oen[1]), .ba_le(le[1]), .ba_clken_n(cen[1]), .ba_clk(pclk[1]),
        .a_in(din[0]), .a_out(a_out), .a_oe(a_oe),
        .b_in(din[1]), .b_out(b_out), .b_oe(b_oe)
    );

    function automatic logic [W-1:0] next_word(logic [W-1:0] st, logic t, logic l,
                                               logic cn, logic c, logic pc, logic [W-1:0] d);
        if (t) return st;
        if (l) return d;
        if (!cn && c && !pc) return d;
        return st;
    endfunction

    function automatic string kind_tag(logic t, logic l, logic cn, logic c, logic pc);
        if (t) return "R8";
        if (l) return "R7";
        if (c && !pc) return cn ? "R2" : "R3";
        return "R4";
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                m_st[d] = '0; m_pc[d] = 1'b0; m_tag[d] = "R9";
            end else begin
                m_tag[d] = kind_tag(test_mode, le[d], cen[d], pclk[d], m_pc[d]);
                m_st[d]  = next_word(m_st[d], test_mode, le[d], cen[d], pclk[d], m_pc[d], din[d]);
                m_pc[d]  = pclk[d];
            end
        end
        test_mode = n_test;
        for (int d = 0; d < 2; d++) begin
            oen[d] = n_oen[d]; le[d] = n_le[d]; cen[d] = n_cen[d];
            pclk[d] = n_pclk[d]; din[d] = n_din[d];
        end
        #1;
        for (int d = 0; d < 2; d++) begin
            logic [W-1:0] eo, ee, ao, ae;
            string t;
            eo = (le[d] && !test_mode) ? din[d] : m_st[d];
            ee = (test_mode || oen[d]) ? '0 : '1;
            ao = (d == 0) ? b_out : a_out;
            ae = (d == 0) ? b_oe : a_oe;
            if (!rst_n) t = "R9";
            else if (test_mode) t = "R8";
            else if (le[d]) t = "R1";
            else t = m_tag[d];
            check(d == 0 ? {t, " R6 ab data"} : {t, " R6 ba data"}, ao, eo);
            check(test_mode ? "R8 oe" : "R5 oe", ae, ee);
        end
    endtask

    task automatic idle_all();
        n_test = 0;
        for (int d = 0; d < 2; d++) begin
            n_oen[d] = 0; n_le[d] = 0; n_cen[d] = 1; n_pclk[d] = 0; n_din[d] = '0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1));
        for (int d = 0; d < 2; d++) begin
            oen[d] = 0; le[d] = 0; cen[d] = 1; pclk[d] = 0; din[d] = '0;
            m_st[d] = '0; m_pc[d] = 0; m_tag[d] = "R9";
        end
        idle_all();
        // R9: reset state, outputs enabled, words zero
        n_din[0] = 20'hABCDE; n_din[1] = 20'h12345;
        repeat (3) cycle();
        @(negedge clk); rst_n = 1'b1;
        // R1: transparency on both paths
        n_le[0] = 1; n_le[1] = 1;
        n_din[0] = 20'h0F0F0; n_din[1] = 20'hF0F0F; cycle();
        n_din[0] = 20'hFFFFF; n_din[1] = 20'h00001; cycle();
        // R7: close latch, last transparent sample kept
        n_le[0] = 0; n_le[1] = 0; n_din[0] = 20'h11111; n_din[1] = 20'h22222; cycle();
        // R3: capture on path 0, R6: path 1 unaffected
        n_cen[0] = 0; n_din[0] = 20'h5A5A5; cycle();
        n_pclk[0] = 1; cycle();
        n_din[0] = 20'h33333; cycle();
        // R4: steady high clock, input changes ignored
        n_din[0] = 20'h44444; repeat (2) cycle();
        // R2: clock enable off, edge ignored
        n_pclk[0] = 0; cycle();
        n_cen[0] = 1; n_pclk[0] = 1; n_din[0] = 20'h77777; cycle();
        cycle();
        // R5: output enable does not disturb word
        n_oen[0] = 1; n_oen[1] = 1; cycle();
        n_oen[0] = 0; cycle();
        // R8: test mode blocks transparency and capture
        n_test = 1; n_le[1] = 1; n_din[1] = 20'h99999; cycle();
        n_le[1] = 0; n_cen[1] = 0; n_pclk[1] = 1; cycle();
        n_test = 0; n_pclk[1] = 0; cycle();
        // random mix
        for (int i = 0; i < 4000; i++) begin
            n_test = ($urandom_range(0, 19) == 0);
            for (int d = 0; d < 2; d++) begin
                n_oen[d]  = ($urandom_range(0, 5) == 0);
                n_le[d]   = ($urandom_range(0, 3) == 0);
                n_cen[d]  = ($urandom_range(0, 2) == 0);
                if ($urandom_range(0, 1) == 1) n_pclk[d] = ~n_pclk[d];
                if ($urandom_range(0, 1) == 1) n_din[d] = W'($urandom);
            end
            cycle();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule